// File: doc/BRIEF.md
# Systolic Matrix-Vector Multiplier

This block computes y = A·x for a small dense matrix A (N rows, M columns) and a vector x of length M, in signed fixed point. It is a linear chain of N processing elements. Element j owns output y_j and accumulates its products into one register. The vector operand is not broadcast. It enters element 0 and moves to the next element through a one-cycle register, so element j sees x one cycle after element j-1.

The host feeds one row of A per lane. Each lane is delayed by its own index, and the slots outside the row are zero, so that every element meets the correct matrix word in the same cycle as the matching vector word. A start pulse clears the accumulators and opens a pass of M+N-1 cycles. At the end of the pass all N results are shown together with a one-cycle valid pulse. They stay on the outputs until the next accepted start.

Words are Q9.23 by default: 32 bits, of which 23 are fractional. Each product is formed at full double width and shifted right by the fraction width, rounding toward minus infinity. It is then added to the accumulator, which clamps at the most positive or most negative word.

Top module: `sysmv_array`

## Requirements
- R1: While reset is held, and after it is released, `busy_o` and `y_valid_o` are 0 and every word of `y_o` is 0.
- R2: A `start_i` high at a clock edge while `busy_o` is 0 is accepted. `busy_o` is then 1 for exactly M+N-1 cycles (pass cycles c = 0 .. M+N-2), beginning the cycle after that edge.
- R3: `y_valid_o` is 1 for exactly one cycle: the first cycle after the last pass cycle, in which `busy_o` is already 0.
- R4: In the valid cycle, word j of `y_o` (bits [j*W +: W]) equals the sum over i = 0..M-1 of floor(a_ji·x_i / 2^FRAC). The sum is taken in ascending i, and the partial sum is clamped after every addition.
- R5: In pass cycle c, lane j of `a_lanes_i` (bits [j*W +: W]) carries a_j,(c-j) when 0 <= c-j < M, and zero otherwise. `x_i` carries x_c for c < M. Values on `x_i` in cycles c >= M have no effect on the results.
- R6: When a partial sum exceeds 2^(W-1)-1 it becomes 2^(W-1)-1. When it falls below -2^(W-1) it becomes -2^(W-1). Later products are added to the clamped value.
- R7: A `start_i` sampled while `busy_o` is 1 is ignored. This includes the last pass cycle. Pass length, valid timing and results are unchanged.
- R8: An accepted start clears all accumulators, so a pass result does not depend on any earlier pass.
- R9: Outside a pass, `y_o` holds its value whatever `a_lanes_i` and `x_i` carry, until the next accepted start.

Ports of the top module, in port-list order:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start of a pass, sampled at the clock edge |
| a_lanes_i | input | N*W | Skewed matrix words, lane j in bits [j*W +: W] |
| x_i | input | W | Vector word entering element 0 |
| busy_o | output | 1 | High during the M+N-1 pass cycles |
| y_o | output | N*W | Result words, y_j in bits [j*W +: W] |
| y_valid_o | output | 1 | One-cycle pulse when the results are complete |

## Verification
The start is driven before edge E0, so pass cycle c runs between edges E_c and E_c+1. `busy_o` is sampled at the falling edge inside each of those cycles. The last product enters element N-1 in cycle M+N-2 and is added at edge E_M+N-1. The results and the valid pulse are therefore checked at the falling edge that follows E_M+N-1, and the valid pulse is checked low again one cycle later. The hold checks sample `y_o` at falling edges during several idle cycles with random inputs. All samples are taken half a period away from the active edge.

// File: rtl/sysmv_pkg.sv
package sysmv_pkg;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_RUN  = 1'b1
   } sysmv_state_t;

   // cycles in one pass: last lane is skewed by n-1 words behind m operands
   function automatic int pass_cycles(input int n, input int m);
      return n + m - 1;
   endfunction

endpackage

// File: rtl/sysmv_ctrl.sv
module sysmv_ctrl
   import sysmv_pkg::*;
#(
   parameter int LEN = 7
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   output logic busy_o,
   output logic clear_o,
   output logic en_o,
   output logic valid_o
);

   localparam int CW = $clog2(LEN + 1);

   sysmv_state_t    state_q;
   logic [CW-1:0]   cnt_q;
   logic            valid_q;
   logic            last_c;

   if (LEN < 1) begin : g_bad_len
      $error("sysmv_ctrl: LEN must be at least 1");
   end

   assign last_c  = (cnt_q == CW'(LEN - 1));
   assign clear_o = start_i && (state_q == ST_IDLE);
   assign en_o    = (state_q == ST_RUN);
   assign busy_o  = (state_q == ST_RUN);
   assign valid_o = valid_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
         valid_q <= 1'b0;
      end else begin
         valid_q <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (start_i) begin
                  state_q <= ST_RUN;
                  cnt_q   <= '0;
               end
            end
            default: begin
               if (last_c) begin
                  state_q <= ST_IDLE;
                  valid_q <= 1'b1;
               end else begin
                  cnt_q <= cnt_q + CW'(1);
               end
            end
         endcase
      end
   end

   a_r2_accept: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && state_q == ST_IDLE) |=> (state_q == ST_RUN && cnt_q == '0));

   a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_RUN) |-> (cnt_q < CW'(LEN)));

   a_r3_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      valid_q |=> !valid_q);

   a_r3_valid_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
      valid_q |-> (!busy_o && $past(busy_o)));

   a_r7_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_RUN && start_i && !last_c) |=>
         (state_q == ST_RUN && cnt_q == $past(cnt_q) + CW'(1)));

endmodule

// File: rtl/sysmv_pe.sv
module sysmv_pe #(
   parameter int W    = 32,
   parameter int FRAC = 23,
   parameter bit SAT  = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                clear_i,
   input  logic                en_i,
   input  logic signed [W-1:0] a_i,
   input  logic signed [W-1:0] x_i,
   output logic signed [W-1:0] acc_o
);

   localparam int PW = 2 * W;
   localparam int SW = PW + 1;
   localparam logic signed [SW-1:0] MAXV = {{(SW-W+1){1'b0}}, {(W-1){1'b1}}};
   localparam logic signed [SW-1:0] MINV = {{(SW-W+1){1'b1}}, {(W-1){1'b0}}};

   logic signed [PW-1:0] a_ext, x_ext, prod, prod_sh;
   logic signed [SW-1:0] sum;
   logic signed [W-1:0]  acc_q, acc_nx;

   assign a_ext   = {{W{a_i[W-1]}}, a_i};
   assign x_ext   = {{W{x_i[W-1]}}, x_i};
   assign prod    = a_ext * x_ext;
   assign prod_sh = prod >>> FRAC;
   assign sum     = {{(SW-W){acc_q[W-1]}}, acc_q} + {prod_sh[PW-1], prod_sh};

   if (SAT) begin : g_sat
      always_comb begin
         if (sum > MAXV)      acc_nx = {1'b0, {(W-1){1'b1}}};
         else if (sum < MINV) acc_nx = {1'b1, {(W-1){1'b0}}};
         else                 acc_nx = sum[W-1:0];
      end
   end else begin : g_wrap
      assign acc_nx = sum[W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       acc_q <= '0;
      else if (clear_i) acc_q <= '0;
      else if (en_i)    acc_q <= acc_nx;
   end

   assign acc_o = acc_q;

   a_r8_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      clear_i |=> (acc_q == '0));

   a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_i && !clear_i) |=> $stable(acc_q));

endmodule

// File: rtl/sysmv_array.sv
module sysmv_array
   import sysmv_pkg::*;
#(
   parameter int N    = 4,
   parameter int M    = 4,
   parameter int W    = 32,
   parameter int FRAC = 23,
   parameter bit SAT  = 1'b1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start_i,
   input  logic [N*W-1:0] a_lanes_i,
   input  logic [W-1:0]   x_i,
   output logic           busy_o,
   output logic [N*W-1:0] y_o,
   output logic           y_valid_o
);

   localparam int LEN = pass_cycles(N, M);

   if (N < 1 || M < 1) begin : g_bad_size
      $error("sysmv_array: N and M must be at least 1");
   end
   if (FRAC < 0 || FRAC >= W) begin : g_bad_frac
      $error("sysmv_array: FRAC must lie in 0 .. W-1");
   end

   logic clear, en;
   logic signed [W-1:0] x_dly [N];

   sysmv_ctrl #(.LEN(LEN)) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (start_i),
      .busy_o  (busy_o),
      .clear_o (clear),
      .en_o    (en),
      .valid_o (y_valid_o)
   );

   assign x_dly[0] = x_i;

   for (genvar j = 1; j < N; j++) begin : g_fwd
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) x_dly[j] <= '0;
         else        x_dly[j] <= x_dly[j-1];
      end
   end

   for (genvar j = 0; j < N; j++) begin : g_pe
      logic signed [W-1:0] acc;

      sysmv_pe #(.W(W), .FRAC(FRAC), .SAT(SAT)) u_pe (
         .clk     (clk),
         .rst_n   (rst_n),
         .clear_i (clear),
         .en_i    (en),
         .a_i     (a_lanes_i[j*W +: W]),
         .x_i     (x_dly[j]),
         .acc_o   (acc)
      );

      assign y_o[j*W +: W] = acc;
   end

   a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!busy_o && !y_valid_o));

   a_r9_results_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && !start_i) |=> $stable(y_o));

endmodule

// File: tb/tb_sysmv_array.sv
module tb_sysmv_array;

   localparam int N = 4, M = 4, W = 32, FRAC = 23;
   localparam int L = N + M - 1;
   localparam longint MAXW = 64'sd2147483647;
   localparam longint MINW = -64'sd2147483648;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start_i = 1'b0;
   logic [N*W-1:0] a_lanes_i = '0;
   logic [W-1:0] x_i = '0;
   logic busy_o, y_valid_o;
   logic [N*W-1:0] y_o;

   logic signed [W-1:0] A [N][M];
   logic signed [W-1:0] X [M];

   int n_checks = 0;
   int n_fail = 0;

   always #2 clk = ~clk;

   sysmv_array #(.N(N), .M(M), .W(W), .FRAC(FRAC)) dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .a_lanes_i(a_lanes_i),
      .x_i(x_i), .busy_o(busy_o), .y_o(y_o), .y_valid_o(y_valid_o)
   );

   task automatic check(input string req, input longint act, input longint exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic longint ref_y(input int j);
      longint acc = 0;
      for (int i = 0; i < M; i++) begin
         longint p = longint'(A[j][i]) * longint'(X[i]);
         acc = acc + (p >>> FRAC);
         if (acc > MAXW) acc = MAXW;
         if (acc < MINW) acc = MINW;
      end
      return acc;
   endfunction

   function automatic longint y_word(input int j);
      return longint'($signed(y_o[j*W +: W]));
   endfunction

   // spur: pass cycle in which a spurious start is raised (-1: none)
   task automatic run_pass(input int spur);
      @(negedge clk);
      start_i = 1'b1;
      for (int c = 0; c < L; c++) begin
         @(negedge clk);
         start_i = (c == spur);
         check((spur >= 0) ? "R7 busy" : "R2 busy", longint'(busy_o), 1);
         for (int j = 0; j < N; j++) begin
            int idx = c - j;
            a_lanes_i[j*W +: W] = (idx >= 0 && idx < M) ? A[j][idx] : '0;
         end
         x_i = (c < M) ? X[c] : $urandom;   // R5 garbage past the vector
      end
      @(negedge clk);
      start_i = 1'b0;
      a_lanes_i = '0;
      check("R2 busy low after pass", longint'(busy_o), 0);
      check("R3 valid", longint'(y_valid_o), 1);
      for (int j = 0; j < N; j++)
         check("R4 R6 result", y_word(j), ref_y(j));
      @(negedge clk);
      check("R3 valid one cycle", longint'(y_valid_o), 0);
   endtask

   function automatic logic signed [W-1:0] rnd_small();
      return $signed($urandom_range(0, 32'h01FF_FFFF)) - 32'sd16777216;
   endfunction

   initial begin
      #(4 * 150000);
      n_fail++;
      $display("FAIL watchdog actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      // R1 reset state
      repeat (3) @(negedge clk);
      check("R1 busy in reset", longint'(busy_o), 0);
      check("R1 valid in reset", longint'(y_valid_o), 0);
      check("R1 y in reset", longint'(y_o == '0), 1);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 busy after reset", longint'(busy_o), 0);
      check("R1 y after reset", longint'(y_o == '0), 1);

      // R4 identity matrix (1.0 = 2^FRAC)
      for (int j = 0; j < N; j++) for (int i = 0; i < M; i++)
         A[j][i] = (i == j) ? 32'sd8388608 : 32'sd0;
      for (int i = 0; i < M; i++) X[i] = rnd_small();
      run_pass(-1);

      // R4 floor rounding of negative products, R5 lane alignment
      for (int j = 0; j < N; j++) for (int i = 0; i < M; i++)
         A[j][i] = (i == j) ? -32'sd1 : 32'sd1;
      for (int i = 0; i < M; i++) X[i] = 32'sd1;
      run_pass(-1);

      // R6 positive and negative clamping, then recovery from the clamp
      for (int j = 0; j < N; j++) for (int i = 0; i < M; i++)
         A[j][i] = 32'sh7FFF_FFFF;
      for (int i = 0; i < M; i++) X[i] = 32'sh7FFF_FFFF;
      A[1][2] = 32'sh8000_0000;
      A[1][3] = 32'sh8000_0000;
      A[2][0] = 32'sh8000_0000;
      A[2][3] = 32'sd0;
      X[3] = 32'sd8388608;
      A[3][0] = 32'sh8000_0000;
      A[3][1] = 32'sd0;
      A[3][2] = 32'sd0;
      run_pass(-1);

      // R8 small pass right after saturated one
      for (int j = 0; j < N; j++) for (int i = 0; i < M; i++) A[j][i] = rnd_small();
      for (int i = 0; i < M; i++) X[i] = rnd_small();
      run_pass(-1);

      // R7 spurious starts in the middle and on the last pass cycle
      run_pass(2);
      run_pass(L - 1);

      // R9 outputs hold while idle inputs change
      begin
         logic [N*W-1:0] held;
         held = y_o;
         for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            a_lanes_i = {$urandom, $urandom, $urandom, $urandom};
            x_i = $urandom;
            check("R9 hold", longint'(y_o == held), 1);
            check("R9 no valid", longint'(y_valid_o), 0);
         end
         a_lanes_i = '0;
      end

      // R4 R6 sweep: small operands, then full-range operands
      for (int t = 0; t < 40; t++) begin
         for (int j = 0; j < N; j++) for (int i = 0; i < M; i++)
            A[j][i] = (t < 20) ? rnd_small() : $signed($urandom);
         for (int i = 0; i < M; i++)
            X[i] = (t < 20) ? rnd_small() : $signed($urandom);
         run_pass((t % 5 == 4) ? (t % L) : -1);
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule